// File: doc/BRIEF.md
# Scan Pattern Shift-Capture Sequencer

The block wraps a register bank of mux-based scan cells and adds a small sequencer that runs test patterns through the cells. In functional mode, each cell is an ordinary D register. The register loads the functional data input on every clock, and the scan path has no effect. When a run starts, the sequencer raises scan enable and shifts a pattern in serially, one bit per clock. It then drops scan enable for a capture window of one or two functional clocks, so that each cell takes its functional input. After that it shifts again.

Every shift pass after the first does two jobs at once. It moves the captured response out on the serial output while the next pattern comes in on the serial input. After the last capture, one extra shift pass of N clocks unloads the final response. The sequencer then reports completion and goes back to functional operation.

A test environment drives start, the pattern count and the capture length. It supplies serial pattern bits in step with scan enable and compares the serial output stream with expected responses.

Top module: `scan_seq_top`

## Requirements
- R1: During reset and in the first cycle after it, every cell reads 0, scan_en_o is 0 and done_o is 0.
- R2: While no run is active (idle or done), scan_en_o is 0 and every cell loads its bit of func_d_i on each clock. func_q_o always shows the cell contents.
- R3: While scan_en_o is 1, cell 0 loads scan_in_i, cell n+1 loads cell n, and scan_out_o shows cell N-1. The bit driven in shift step k (counted from 0) ends in cell N-1-k after N steps, so a pattern enters MSB first.
- R4: When start_i is seen while idle or done with a non-zero pattern count, scan_en_o goes to 1 in the next cycle. Every shift pass keeps it at 1 for exactly N consecutive cycles.
- R5: The capture window holds scan_en_o at 0 for one cycle when cap_len_i was 0 at start, and for two cycles when it was 1. A change on cap_len_i after start has no effect on the run.
- R6: After each capture that is not the last, the next N-cycle shift pass loads the next pattern. In the same pass it presents the captured response on scan_out_o, MSB first.
- R7: A run with pattern count P performs P loads and P captures. These are followed by one unload-only pass of N cycles, after which done_o rises.
- R8: done_o stays at 1, with scan_en_o at 0, until the next start_i.
- R9: A start with a pattern count of 0 sets done_o in the next cycle and performs no shift.
- R10: start_i, pat_count_i and cap_len_i are ignored while a run is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (sampled while idle or done) |
| pat_count_i | input | PCNT_W | Number of patterns in the run |
| cap_len_i | input | 1 | Capture window length: 0 for one cycle, 1 for two cycles |
| scan_in_i | input | 1 | Serial pattern input |
| scan_out_o | output | 1 | Serial response output (last cell) |
| func_d_i | input | N_CELLS | Functional data into the cells |
| func_q_o | output | N_CELLS | Cell contents |
| scan_en_o | output | 1 | Scan enable driven to the cells |
| done_o | output | 1 | Run complete |

## Verification
The hardest case to reach is the two-cycle capture. Its result only differs from a one-cycle capture if the functional input changes between the two capture clocks. To produce that change, the bench feeds func_d_i from a next-state function of func_q_o, a rotate combined with a constant mask. The expected response is then that function applied once or twice to the loaded pattern. These expected responses are checked bit by bit against the overlapped unload stream. They are also checked during the final unload-only pass. During the run, the bench toggles cap_len_i and pulses start_i so that the sampled settings are shown to hold.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SHIFT   = 3'd1,
    ST_CAPTURE = 3'd2,
    ST_UNLOAD  = 3'd3,
    ST_DONE    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic se_i,
  input  logic d_i,
  input  logic si_i,
  output logic q_o
);
  logic d_sel;
  assign d_sel = se_i ? si_i : d_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_sel;
  end
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               se_i,
  input  logic               si_i,
  input  logic [N_CELLS-1:0] d_i,
  output logic [N_CELLS-1:0] q_o,
  output logic               so_o
);
  logic [N_CELLS:0] link;
  assign link[0] = si_i;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    scan_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .se_i  (se_i),
      .d_i   (d_i[g]),
      .si_i  (link[g]),
      .q_o   (q_o[g])
    );
    assign link[g+1] = q_o[g];
  end

  assign so_o = link[N_CELLS];
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_seq_pkg::*;
#(
  parameter int unsigned N_CELLS = 8,
  parameter int unsigned PCNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PCNT_W-1:0] pat_count_i,
  input  logic              cap_len_i,
  output logic              scan_en_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(N_CELLS - 1);

  seq_state_e        state_q;
  logic [CNT_W-1:0]  step_q;
  logic [PCNT_W-1:0] left_q;
  logic              cap_two_q;
  logic              cap_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      left_q    <= '0;
      cap_two_q <= 1'b0;
      cap_cnt_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            cap_two_q <= cap_len_i;
            left_q    <= pat_count_i;
            step_q    <= '0;
            state_q   <= (pat_count_i == '0) ? ST_DONE : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (step_q == LAST_STEP) begin
            cap_cnt_q <= 1'b0;
            state_q   <= ST_CAPTURE;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        ST_CAPTURE: begin
          if (!cap_two_q || cap_cnt_q) begin
            left_q  <= left_q - 1'b1;
            step_q  <= '0;
            state_q <= (left_q == PCNT_W'(1)) ? ST_UNLOAD : ST_SHIFT;
          end else begin
            cap_cnt_q <= 1'b1;
          end
        end
        ST_UNLOAD: begin
          if (step_q == LAST_STEP) state_q <= ST_DONE;
          else                     step_q  <= step_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scan_en_o = (state_q == ST_SHIFT) || (state_q == ST_UNLOAD);
  assign done_o    = (state_q == ST_DONE);
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int unsigned N_CELLS = 8,
  parameter int unsigned PCNT_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [PCNT_W-1:0]  pat_count_i,
  input  logic               cap_len_i,
  input  logic               scan_in_i,
  output logic               scan_out_o,
  input  logic [N_CELLS-1:0] func_d_i,
  output logic [N_CELLS-1:0] func_q_o,
  output logic               scan_en_o,
  output logic               done_o
);
  logic se;

  scan_ctrl #(.N_CELLS(N_CELLS), .PCNT_W(PCNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .pat_count_i(pat_count_i),
    .cap_len_i  (cap_len_i),
    .scan_en_o  (se),
    .done_o     (done_o)
  );

  scan_chain #(.N_CELLS(N_CELLS)) u_chain (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .se_i  (se),
    .si_i  (scan_in_i),
    .d_i   (func_d_i),
    .q_o   (func_q_o),
    .so_o  (scan_out_o)
  );

  assign scan_en_o = se;
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int unsigned N_CELLS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               scan_in_i,
  input logic [N_CELLS-1:0] func_d_i,
  input logic [N_CELLS-1:0] func_q_o,
  input logic               scan_en_o,
  input logic               done_o
);
  localparam int unsigned RUN_W = $clog2(N_CELLS + 2) + 1;

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  run_q <= '0;
    else if (!scan_en_o)          run_q <= '0;
    else if (run_q != '1)         run_q <= run_q + 1'b1;
  end

  AST_SHIFT_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |=> (func_q_o[0] == $past(scan_in_i)) &&
                  (func_q_o[N_CELLS-1:1] == $past(func_q_o[N_CELLS-2:0]))); // R3

  AST_FUNC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_o |=> func_q_o == $past(func_d_i)); // R2

  AST_PASS_NOT_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |-> run_q < RUN_W'(N_CELLS)); // R4

  AST_PASS_NOT_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_o && run_q != '0) |-> run_q == RUN_W'(N_CELLS)); // R4

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !scan_en_o); // R8

  AST_DONE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R8
endmodule

bind scan_seq_top scan_seq_chk #(.N_CELLS(N_CELLS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .scan_in_i(scan_in_i),
  .func_d_i (func_d_i),
  .func_q_o (func_q_o),
  .scan_en_o(scan_en_o),
  .done_o   (done_o)
);

// File: tb/scan_seq_top_tb_top.sv
module scan_seq_top_tb_top;
  localparam int unsigned N          = 8;
  localparam int unsigned PW         = 4;
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [N-1:0] MASK      = 8'h5A;

  typedef struct packed {
    logic       cap_two;
    logic [1:0] npat;
    logic [7:0] p0;
    logic [7:0] p1;
    logic [7:0] p2;
  } job_t;

  localparam job_t JOBS [4] = '{
    '{1'b0, 2'd1, 8'hA5, 8'h00, 8'h00},
    '{1'b1, 2'd2, 8'h3C, 8'hC3, 8'h00},
    '{1'b0, 2'd3, 8'hF0, 8'h0F, 8'h81},
    '{1'b1, 2'd3, 8'hFF, 8'h00, 8'h96}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [PW-1:0] pat_count_i = '0;
  logic cap_len_i = 1'b0;
  logic scan_in_i = 1'b0;
  logic scan_out_o;
  logic [N-1:0] func_d_i;
  logic [N-1:0] func_q_o;
  logic scan_en_o;
  logic done_o;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic logic [N-1:0] next_f(input logic [N-1:0] q);
    return {q[N-2:0], q[N-1]} ^ MASK;
  endfunction

  function automatic logic [N-1:0] resp(input logic [N-1:0] p, input logic two);
    return two ? next_f(next_f(p)) : next_f(p);
  endfunction

  assign func_d_i = next_f(func_q_o);

  scan_seq_top #(.N_CELLS(N), .PCNT_W(PW)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .pat_count_i(pat_count_i),
    .cap_len_i  (cap_len_i),
    .scan_in_i  (scan_in_i),
    .scan_out_o (scan_out_o),
    .func_d_i   (func_d_i),
    .func_q_o   (func_q_o),
    .scan_en_o  (scan_en_o),
    .done_o     (done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_functional(input string req);
    for (int i = 0; i < 3; i++) begin
      logic [N-1:0] prev;
      prev = func_q_o;
      chk(scan_en_o == 1'b0, req, 32'(scan_en_o), 0);
      @(negedge clk_i);
      chk(func_q_o == next_f(prev), req, 32'(func_q_o), 32'(next_f(prev)));
    end
  endtask

  // poke: pulse start_i with other settings in the middle of the first load (R10)
  task automatic run_job(input job_t j, input bit poke);
    logic [N-1:0] pp [3];
    logic [N-1:0] exp_r;
    int ncap;
    pp[0] = j.p0; pp[1] = j.p1; pp[2] = j.p2;
    ncap = j.cap_two ? 2 : 1;
    start_i = 1'b1; pat_count_i = PW'(j.npat); cap_len_i = j.cap_two;
    @(negedge clk_i);
    start_i = 1'b0;
    cap_len_i = ~j.cap_two; // R5: must be ignored
    for (int i = 0; i < int'(j.npat); i++) begin
      for (int k = 0; k < N; k++) begin
        chk(scan_en_o == 1'b1, "R4", 32'(scan_en_o), 1);
        scan_in_i = pp[i][N-1-k];
        if (i > 0) chk(scan_out_o == exp_r[N-1-k], "R6", 32'(scan_out_o), 32'(exp_r[N-1-k]));
        if (poke && i == 0 && k == 3) begin start_i = 1'b1; pat_count_i = 4'd9; end
        if (poke && i == 0 && k == 4) begin start_i = 1'b0; pat_count_i = 4'd0; end
        @(negedge clk_i);
      end
      chk(func_q_o == pp[i], "R3", 32'(func_q_o), 32'(pp[i]));
      for (int c = 0; c < ncap; c++) begin
        chk(scan_en_o == 1'b0, "R5", 32'(scan_en_o), 0);
        @(negedge clk_i);
      end
      exp_r = resp(pp[i], j.cap_two);
      chk(func_q_o == exp_r, "R5", 32'(func_q_o), 32'(exp_r));
    end
    for (int k = 0; k < N; k++) begin
      chk(scan_en_o == 1'b1, "R7", 32'(scan_en_o), 1);
      chk(done_o == 1'b0, "R7", 32'(done_o), 0);
      chk(scan_out_o == exp_r[N-1-k], "R7", 32'(scan_out_o), 32'(exp_r[N-1-k]));
      @(negedge clk_i);
    end
    chk(done_o == 1'b1, "R7", 32'(done_o), 1);
    chk(scan_en_o == 1'b0, "R8", 32'(scan_en_o), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 2);
    chk(func_q_o == '0, "R1", 32'(func_q_o), 0);
    chk(scan_en_o == 1'b0, "R1", 32'(scan_en_o), 0);
    chk(done_o == 1'b0, "R1", 32'(done_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R1", 32'(done_o), 0);

    // R2: ordinary registers while idle
    check_functional("R2");

    // vector table
    for (int t = 0; t < 4; t++) begin
      run_job(JOBS[t], 1'b0);
      repeat (2) begin
        @(negedge clk_i);
        chk(done_o == 1'b1, "R8", 32'(done_o), 1);
      end
      check_functional("R2");
    end

    // R10: start and count pulsed mid-run
    run_job('{1'b0, 2'd2, 8'h69, 8'h18, 8'h00}, 1'b1);
    @(negedge clk_i);
    chk(done_o == 1'b1, "R10", 32'(done_o), 1);

    // R9: zero patterns
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk(done_o == 1'b1, "R9", 32'(done_o), 1);
    start_i = 1'b1; pat_count_i = '0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b1, "R9", 32'(done_o), 1);
    chk(scan_en_o == 1'b0, "R9", 32'(scan_en_o), 0);
    @(negedge clk_i);
    chk(scan_en_o == 1'b0, "R9", 32'(scan_en_o), 0);

    // R8 done clears on restart, then one-pattern run completes
    start_i = 1'b1; pat_count_i = 4'd1; cap_len_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o == 1'b0, "R8", 32'(done_o), 0);
    chk(scan_en_o == 1'b1, "R4", 32'(scan_en_o), 1);
    repeat (N + 2 + N) @(negedge clk_i);
    chk(done_o == 1'b1, "R8", 32'(done_o), 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule